// File: doc/BRIEF.md
# Configuration Window Base Decoder

This block holds a 64-bit base register that software programs through a small byte-enabled register port. From that register it derives where a memory-mapped configuration window sits in a 36-bit physical address space. Bit 0 of the register turns the window on. A two-bit length field at bits 2:1 selects one of three window sizes: 256 MiB, 128 MiB or 64 MiB. The same field decides how many base bits below bit 28 survive the alignment mask. The fourth length code is reserved.

A write that touches at least one byte of the register moves a two-state controller from `CW_IDLE` into `CW_APPLY`. In `CW_APPLY` the registered window outputs (base, size and valid) are rebuilt from the stored register. The one exception is the reserved length code: in that case the window is left as it was and a length error flag is raised. `CW_APPLY` returns to `CW_IDLE` unless another touching write arrives in the same cycle. A touching write in that cycle holds the controller in `CW_APPLY`.

A combinational comparator checks a probe address against the decoded window every cycle, so address routing logic elsewhere can steer configuration accesses.

Top module: `cfg_window_decoder`

## Requirements
- R1: After reset the register reads 0xB000_0000 at offset 0x60 and 0x0000_0000 at offset 0x64. The window is base 0xB000_0000, size 256 MiB, not valid, with the length error flag clear.
- R2: The low register word is at offset 0x60 and the high word at 0x64. A write changes only the bytes whose byte enable is set. Reads at either offset return the stored word. Any other offset reads zero, and writes to it change nothing.
- R3: The window valid output equals register bit 0 at the last apply. While the window is not valid, the hit output stays low.
- R4: Length code 00 gives a 256 MiB window whose base keeps register bits 35:28.
- R5: Length code 01 gives a 128 MiB window whose base keeps register bits 35:27.
- R6: Length code 10 gives a 64 MiB window whose base keeps register bits 35:26.
- R7: Applying length code 11 leaves base, size and valid unchanged and sets the length error flag. The next apply with a legal code clears the flag.
- R8: A write with at least one byte enable set, to either register word, updates the window outputs on the second rising edge after the write is presented. The window does not change on the first edge. A write with no byte enables does not recompute the window.
- R9: The hit output is high in the same cycle for any probe address with (addr & ~(size-1)) equal to the base while the window is valid. It is low for any other address.
- R10: Register bits above 35 are stored and read back, but they never reach the decoded base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for the write |
| reg_rdata | output | 32 | Read data for reg_addr |
| win_base | output | 36 | Decoded window base |
| win_size | output | 36 | Decoded window size in bytes |
| win_valid | output | 1 | Window enabled |
| len_err | output | 1 | Reserved length code was applied |
| probe_addr | input | 36 | Physical address to test |
| probe_hit | output | 1 | probe_addr falls in the window |

## Verification
Register storage lands on the first rising edge after a write is presented. The window outputs and the error flag follow on the second edge, and read data and the hit output settle combinationally within the same cycle. The bench drives every input on a falling edge. It checks the window only after two rising edges have passed, and once, in a directed case, after exactly one edge to confirm the old window is still there. Read-back and hit checks are taken 1 ns after the address changes, away from any clock edge.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    typedef enum logic [1:0] {
        LEN_256M = 2'b00,
        LEN_128M = 2'b01,
        LEN_64M  = 2'b10,
        LEN_RSVD = 2'b11
    } win_len_e;

    typedef enum logic {
        CW_IDLE  = 1'b0,
        CW_APPLY = 1'b1
    } cw_state_e;

    localparam int EN_BIT  = 0;
    localparam int LEN_LSB = 1;

endpackage

// File: rtl/cwd_regs.sv
module cwd_regs #(
    parameter int AW     = 8,
    parameter int DATA_W = 32,
    parameter int WORDS  = 2,
    parameter int DEC_W  = 36,
    parameter logic [AW-1:0] BASE_OFS = 8'h60,
    parameter logic [WORDS*DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0] rdata,
    output logic [DEC_W-1:0]  dec_src,
    output logic              touch
);
    localparam int BYTES = DATA_W / 8;
    localparam int REG_W = WORDS * DATA_W;

    logic [REG_W-1:0] reg_q;
    logic [WORDS-1:0] sel;

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_sel
            assign sel[w] = (addr == AW'(int'(BASE_OFS) + w * BYTES));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= RESET_VAL;
        end else if (wr_en) begin
            for (int w = 0; w < WORDS; w++) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (sel[w] && be[b]) begin
                        reg_q[w*DATA_W + b*8 +: 8] <= wdata[b*8 +: 8];
                    end
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (sel[w]) begin
                rdata = reg_q[w*DATA_W +: DATA_W];
            end
        end
    end

    assign touch   = wr_en && (|sel) && (|be);
    assign dec_src = reg_q[DEC_W-1:0];

endmodule

// File: rtl/cwd_decode.sv
module cwd_decode
    import cwd_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int BASE_LO = 28
) (
    input  logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] size,
    output logic              enable,
    output logic              reserved
);
    win_len_e len;

    assign len    = win_len_e'(src[LEN_LSB +: 2]);
    assign enable = src[EN_BIT];

    always_comb begin
        reserved = 1'b0;
        unique case (len)
            LEN_256M: size = ADDR_W'(1) << BASE_LO;
            LEN_128M: size = ADDR_W'(1) << (BASE_LO - 1);
            LEN_64M:  size = ADDR_W'(1) << (BASE_LO - 2);
            LEN_RSVD: begin
                size     = ADDR_W'(1) << BASE_LO;
                reserved = 1'b1;
            end
        endcase
    end

    assign base = src & ~(size - ADDR_W'(1));

endmodule

// File: rtl/cwd_hit.sv
module cwd_hit #(
    parameter int ADDR_W = 36
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    input  logic              valid,
    output logic              hit
);
    logic [ADDR_W-1:0] masked;

    assign masked = addr & ~(size - ADDR_W'(1));
    assign hit    = valid && (masked == base);

endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
    import cwd_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 36,
    parameter int BASE_LO = 28,
    parameter logic [AW-1:0] REG_OFS = 8'h60,
    parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [DATA_W/8-1:0] reg_be,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [ADDR_W-1:0]   win_base,
    output logic [ADDR_W-1:0]   win_size,
    output logic                win_valid,
    output logic                len_err,
    input  logic [ADDR_W-1:0]   probe_addr,
    output logic                probe_hit
);
    localparam int WORDS = 64 / DATA_W;

    cw_state_e state_q, state_d;

    logic              touch;
    logic              apply;
    logic [ADDR_W-1:0] dec_src;
    logic [ADDR_W-1:0] dec_base;
    logic [ADDR_W-1:0] dec_size;
    logic              dec_enable;
    logic              dec_reserved;

    logic [ADDR_W-1:0] win_base_q;
    logic [ADDR_W-1:0] win_size_q;
    logic              win_valid_q;
    logic              len_err_q;

    cwd_regs #(
        .AW(AW), .DATA_W(DATA_W), .WORDS(WORDS), .DEC_W(ADDR_W),
        .BASE_OFS(REG_OFS), .RESET_VAL(RESET_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .be(reg_be), .rdata(reg_rdata),
        .dec_src(dec_src), .touch(touch)
    );

    cwd_decode #(.ADDR_W(ADDR_W), .BASE_LO(BASE_LO)) u_dec (
        .src(dec_src), .base(dec_base), .size(dec_size),
        .enable(dec_enable), .reserved(dec_reserved)
    );

    // Next state: any touching write schedules one apply cycle
    always_comb begin
        unique case (state_q)
            CW_IDLE:  state_d = touch ? CW_APPLY : CW_IDLE;
            CW_APPLY: state_d = touch ? CW_APPLY : CW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CW_IDLE;
        else        state_q <= state_d;
    end

    assign apply = (state_q == CW_APPLY);

    // Output process: window registers rebuilt in CW_APPLY
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_base_q  <= dec_base;
            win_size_q  <= dec_size;
            win_valid_q <= dec_enable && !dec_reserved;
            len_err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                CW_IDLE: begin
                end
                CW_APPLY: begin
                    if (dec_reserved) begin
                        len_err_q <= 1'b1;
                    end else begin
                        win_base_q  <= dec_base;
                        win_size_q  <= dec_size;
                        win_valid_q <= dec_enable;
                        len_err_q   <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign win_base  = win_base_q;
    assign win_size  = win_size_q;
    assign win_valid = win_valid_q;
    assign len_err   = len_err_q;

    cwd_hit #(.ADDR_W(ADDR_W)) u_hit (
        .addr(probe_addr), .base(win_base_q), .size(win_size_q),
        .valid(win_valid_q), .hit(probe_hit)
    );

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
    parameter int ADDR_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              touch,
    input logic              apply,
    input logic              dec_reserved,
    input logic              dec_enable,
    input logic [ADDR_W-1:0] win_base,
    input logic [ADDR_W-1:0] win_size,
    input logic              win_valid,
    input logic              len_err,
    input logic              probe_hit
);
    assert_touch_schedules_apply_R8: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> apply);

    assert_idle_holds_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(win_base) && $stable(win_size) && $stable(win_valid)));

    assert_reserved_keeps_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && dec_reserved) |=> ($stable(win_base) && $stable(win_size) && $stable(win_valid) && len_err));

    assert_legal_apply_clears_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !dec_reserved) |=> !len_err);

    assert_apply_loads_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !dec_reserved) |=> (win_valid == $past(dec_enable)));

    assert_base_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_base & (win_size - ADDR_W'(1))) == '0);

    assert_size_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(win_size) == 1);

    assert_hit_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        probe_hit |-> win_valid);

endmodule

bind cfg_window_decoder cwd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .touch(touch), .apply(apply),
    .dec_reserved(dec_reserved), .dec_enable(dec_enable),
    .win_base(win_base), .win_size(win_size), .win_valid(win_valid),
    .len_err(len_err), .probe_hit(probe_hit)
);

// File: tb/tb_cfg_window_decoder.sv
`timescale 1ns/1ps
module tb_cfg_window_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h60;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_rdata;
    logic [35:0] win_base, win_size;
    logic        win_valid, len_err;
    logic [35:0] probe_addr = '0;
    logic        probe_hit;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [63:0] m_reg;
    logic [35:0] m_base, m_size;
    logic        m_valid, m_err;

    always #2 clk = ~clk;

    cfg_window_decoder dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
        .win_base(win_base), .win_size(win_size), .win_valid(win_valid),
        .len_err(len_err), .probe_addr(probe_addr), .probe_hit(probe_hit)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_hit(logic [35:0] a);
        return m_valid && ((a & ~(m_size - 36'd1)) == m_base);
    endfunction

    task automatic model_apply();
        logic [1:0] len;
        len = m_reg[2:1];
        if (len == 2'b11) begin
            m_err = 1'b1;
        end else begin
            m_size  = 36'd1 << (28 - len);
            m_base  = m_reg[35:0] & ~(m_size - 36'd1);
            m_valid = m_reg[0];
            m_err   = 1'b0;
        end
    endtask

    task automatic model_write(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        int w;
        w = (a == 8'h60) ? 0 : (a == 8'h64) ? 1 : -1;
        if (w >= 0 && be != 4'b0) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) m_reg[w*32 + b*8 +: 8] = d[b*8 +: 8];
            model_apply();
        end
    endtask

    // Present at a falling edge, write lands on the next rising edge
    task automatic present(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'b0;
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        present(a, d, be);
        model_write(a, d, be);
        @(negedge clk);
    endtask

    task automatic check_window(string req);
        chk(req, "win_base", 64'(win_base), 64'(m_base));
        chk(req, "win_size", 64'(win_size), 64'(m_size));
        chk(req, "win_valid", 64'(win_valid), 64'(m_valid));
        chk(req, "len_err", 64'(len_err), 64'(m_err));
    endtask

    task automatic check_reads(string req);
        reg_addr = 8'h60; #1;
        chk(req, "read low word", 64'(reg_rdata), 64'(m_reg[31:0]));
        reg_addr = 8'h64; #1;
        chk(req, "read high word", 64'(reg_rdata), 64'(m_reg[63:32]));
    endtask

    task automatic probe(string req, logic [35:0] a);
        probe_addr = a; #1;
        chk(req, "probe_hit", 64'(probe_hit), 64'(exp_hit(a)));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL R8 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_val;
        seed_val = $urandom(32'd917);
        m_reg = 64'h0000_0000_B000_0000;
        m_size = 36'd1 << 28; m_base = 36'hB000_0000; m_valid = 1'b0; m_err = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_reads("R1");
        check_window("R1");
        probe("R3", 36'hB000_0000);

        // R8 timing: window unchanged after one edge, updated after two
        present(8'h60, 32'hE000_0001, 4'hF);
        #1;
        chk("R8", "base after one edge", 64'(win_base), 64'(m_base));
        model_write(8'h60, 32'hE000_0001, 4'hF);
        @(negedge clk);
        check_window("R4");
        probe("R9", 36'hEFFF_FFFF);
        probe("R9", 36'hF000_0000);
        probe("R9", 36'hDFFF_FFFF);

        bus_write(8'h60, 32'hE800_0003, 4'hF);
        check_window("R5");
        probe("R5", 36'hEFFF_FFFF);
        probe("R5", 36'hE7FF_FFFF);

        bus_write(8'h60, 32'hEC00_0005, 4'hF);
        check_window("R6");
        probe("R6", 36'hEFFF_FFFF);
        probe("R6", 36'hEBFF_FFFF);

        bus_write(8'h60, 32'hD000_0007, 4'hF);
        check_window("R7");
        chk("R7", "len_err", 64'(len_err), 64'd1);
        check_reads("R2");

        bus_write(8'h60, 32'h1000_0001, 4'hF);
        check_window("R7");

        bus_write(8'h64, 32'hFFFF_FFF5, 4'b0001);
        check_window("R10");
        chk("R10", "base", 64'(win_base), 64'h5_1000_0000);
        check_reads("R2");

        bus_write(8'h60, 32'hFFFF_FFFF, 4'b0000);
        check_window("R8");
        check_reads("R8");

        bus_write(8'h10, 32'hFFFF_FFFF, 4'hF);
        reg_addr = 8'h10; #1;
        chk("R2", "read unmapped", 64'(reg_rdata), 64'd0);
        check_window("R2");
        check_reads("R2");

        bus_write(8'h60, 32'h0000_0000, 4'b0001);
        check_window("R3");
        probe("R3", 36'h5_1000_0000);

        for (int i = 0; i < 300; i++) begin
            logic [7:0]  a;
            logic [31:0] r;
            logic [35:0] off;
            r = $urandom;
            a = (r[2:0] < 3) ? 8'h60 : (r[2:0] < 6) ? 8'h64 : 8'($urandom);
            bus_write(a, $urandom, 4'($urandom));
            check_window("R8");
            check_reads("R2");
            off = {$urandom, $urandom} & (m_size - 36'd1);
            probe("R9", m_base + off);
            probe("R9", m_base - 36'd1);
            probe("R9", m_base + m_size);
            probe("R9", {$urandom, $urandom});
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule